// File: doc/BRIEF.md
# Rotating-Priority Output Allocator with Held Path

This block owns one output port of a bufferless circuit-switched router. Each input-side steering unit that may reach this output raises a request line. On an idle output the allocator chooses a single winner with a rotating priority, then latches that winner as the owner of the output. From then on the owner's data bus is passed straight through to the output with no storage in between, and the selection does not change until a release pulse tears the path down.

Requesters that do not win are answered with a reject, whether they lost a same-cycle contest or arrived while the output was already held. A rejected source is expected to back off and retry later; the allocator keeps no queue of waiting requests. Routing decisions and address comparison happen upstream and are not part of this block.

Top module: `output_allocator`

## Requirements
- R1: After reset, `grant_o` and `reject_o` are all zero, `busy_o` is low and `data_o` is zero.
- R2: When the output is free and at least one request line is high at a clock edge, from that edge on `busy_o` is high and `grant_o` is one-hot, naming the chosen input (bit i of `grant_o` belongs to input i).
- R3: The choice scans inputs in ascending index order, starting at the input one above the most recent winner and wrapping from the highest index back to input 0; after reset the scan starts at input 0.
- R4: The scan starting point moves only when a grant is issued; cycles with no request, or with the output held, leave it unchanged.
- R5: When several inputs request in the same cycle, exactly one is granted and every other requester sees `reject_o` high for the cycle after that edge.
- R6: While held, `grant_o` stays constant every cycle until a release is sampled, even if the owner drops its request.
- R7: A request from any input other than the owner, sampled while the output is held, is answered by its `reject_o` bit in the following cycle; the owner is never rejected.
- R8: A high `release_i` sampled while held frees the output at that edge (`grant_o` zero, `busy_o` low in the next cycle); a pending request can win at the edge after that.
- R9: `release_i` sampled while the output is free has no effect: a request in that same cycle is granted normally.
- R10: `data_o` equals the owner's slice of `data_i` (input i on bits i*DATA_W upward) combinationally while held, and is zero while free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_IN | Per-input request for this output |
| data_i | input | N_IN*DATA_W | Data buses of all inputs, input i at bits [i*DATA_W +: DATA_W] |
| release_i | input | 1 | Tear down the held path |
| grant_o | output | N_IN | One-hot owner of the output while held |
| reject_o | output | N_IN | One-cycle refusal to a requester |
| data_o | output | DATA_W | Forwarded data of the owner |
| busy_o | output | 1 | Output is held by an owner |

## Verification
The bench builds the block with three inputs and an eight-bit data path, the wider of the two fan-ins the router uses. Three inputs make it possible to have two losers in one contest, to see the scan wrap from input 2 back to input 0, and to tell a pointer that stayed put over idle cycles from one that drifted. Distinct byte values per input, with one changed while held, expose a mux that picks the wrong slice or samples instead of passing through.

// File: rtl/oalloc_pkg.sv
package oalloc_pkg;

    typedef enum logic {
        PATH_FREE = 1'b0,
        PATH_HELD = 1'b1
    } path_state_e;

    // Index following cur in a ring of n entries.
    function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/rr_priority.sv
module rr_priority #(
    parameter int N_IN  = 3,
    parameter int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  req,
    input  logic             advance,
    input  logic [IDX_W-1:0] win_idx,
    output logic             pick_valid,
    output logic [IDX_W-1:0] pick_idx
);
    import oalloc_pkg::*;

    logic [IDX_W-1:0] start_q;

    // First requester at or above start_q, wrapping around.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int off = N_IN - 1; off >= 0; off--) begin
            int unsigned cand;
            cand = (int'(start_q) + off) % N_IN;
            if (req[cand]) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (advance) begin
            start_q <= IDX_W'(ring_next({{(32-IDX_W){1'b0}}, win_idx}, N_IN));
        end
    end

endmodule

// File: rtl/path_latch.sv
module path_latch #(
    parameter int N_IN  = 3,
    parameter int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  req,
    input  logic             pick_valid,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             release_i,
    output logic             take,
    output logic [N_IN-1:0]  grant,
    output logic [N_IN-1:0]  reject,
    output logic             held
);
    import oalloc_pkg::*;

    path_state_e      state_q;
    logic [IDX_W-1:0] owner_q;
    logic [N_IN-1:0]  reject_q;
    logic [N_IN-1:0]  keep_mask;

    assign take = (state_q == PATH_FREE) && pick_valid;

    // Inputs that are not refused this cycle: the new winner or the owner.
    always_comb begin
        keep_mask = '0;
        if (take) begin
            keep_mask[pick_idx] = 1'b1;
        end else if (state_q == PATH_HELD) begin
            keep_mask[owner_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PATH_FREE;
            owner_q  <= '0;
            reject_q <= '0;
        end else begin
            reject_q <= req & ~keep_mask;
            if (take) begin
                state_q <= PATH_HELD;
                owner_q <= pick_idx;
            end else if (state_q == PATH_HELD && release_i) begin
                state_q <= PATH_FREE;
            end
        end
    end

    always_comb begin
        grant = '0;
        if (state_q == PATH_HELD) begin
            grant[owner_q] = 1'b1;
        end
    end

    assign reject = reject_q;
    assign held   = (state_q == PATH_HELD);

endmodule

// File: rtl/grant_mux.sv
module grant_mux #(
    parameter int N_IN   = 3,
    parameter int DATA_W = 8
) (
    input  logic [N_IN-1:0]        sel,
    input  logic [N_IN*DATA_W-1:0] din,
    output logic [DATA_W-1:0]      dout
);
    logic [DATA_W-1:0] gated [N_IN];

    // AND-OR mux steered directly by the one-hot grant lines.
    for (genvar i = 0; i < N_IN; i++) begin : g_lane
        assign gated[i] = din[i*DATA_W +: DATA_W] & {DATA_W{sel[i]}};
    end

    always_comb begin
        dout = '0;
        for (int i = 0; i < N_IN; i++) begin
            dout = dout | gated[i];
        end
    end

endmodule

// File: rtl/output_allocator.sv
module output_allocator #(
    parameter int N_IN   = 3,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN-1:0]        req_i,
    input  logic [N_IN*DATA_W-1:0] data_i,
    input  logic                   release_i,
    output logic [N_IN-1:0]        grant_o,
    output logic [N_IN-1:0]        reject_o,
    output logic [DATA_W-1:0]      data_o,
    output logic                   busy_o
);
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    logic             take;

    rr_priority #(.N_IN(N_IN), .IDX_W(IDX_W)) u_prio (
        .clk        (clk),
        .rst        (rst),
        .req        (req_i),
        .advance    (take),
        .win_idx    (pick_idx),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    path_latch #(.N_IN(N_IN), .IDX_W(IDX_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .req        (req_i),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .release_i  (release_i),
        .take       (take),
        .grant      (grant_o),
        .reject     (reject_o),
        .held       (busy_o)
    );

    grant_mux #(.N_IN(N_IN), .DATA_W(DATA_W)) u_mux (
        .sel  (grant_o),
        .din  (data_i),
        .dout (data_o)
    );

endmodule

// File: rtl/alloc_chk.sv
module alloc_chk #(
    parameter int N_IN   = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [N_IN-1:0]   req_i,
    input logic              release_i,
    input logic [N_IN-1:0]   grant_o,
    input logic [N_IN-1:0]   reject_o,
    input logic [DATA_W-1:0] data_o,
    input logic              busy_o
);
    // R2
    idle_req_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (|req_i)) |=> busy_o);

    // R5
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o) && (busy_o == (|grant_o)));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !release_i) |=> ($stable(grant_o) && busy_o));

    // R7
    owner_not_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o & reject_o) == '0);

    // R7
    refuse_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !release_i) |=> (reject_o == $past(req_i & ~grant_o)));

    // R8
    release_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && release_i) |=> !busy_o);

    // R10
    free_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (data_o == '0));

endmodule

bind output_allocator alloc_chk #(.N_IN(N_IN), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .release_i (release_i),
    .grant_o   (grant_o),
    .reject_o  (reject_o),
    .data_o    (data_o),
    .busy_o    (busy_o)
);

// File: tb/sim_output_allocator.sv
module sim_output_allocator;
    localparam int N  = 3;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    req_i = '0;
    logic [N*DW-1:0] data_i = '0;
    logic            release_i = 1'b0;
    logic [N-1:0]    grant_o;
    logic [N-1:0]    reject_o;
    logic [DW-1:0]   data_o;
    logic            busy_o;

    typedef struct {
        logic [N-1:0]  g;
        logic [N-1:0]  rj;
        logic          b;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    output_allocator #(.N_IN(N), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .data_i(data_i),
        .release_i(release_i), .grant_o(grant_o), .reject_o(reject_o),
        .data_o(data_o), .busy_o(busy_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply inputs at a falling edge, queue the result due after the next rising edge.
    task automatic step(input logic [N-1:0] r, input logic rel, input logic [N*DW-1:0] dv,
                        input logic [N-1:0] g, input logic [N-1:0] rj, input logic b,
                        input logic [DW-1:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        req_i = r; release_i = rel; data_i = dv;
        e.g = g; e.rj = rj; e.b = b; e.d = d; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "grant",  32'(grant_o),  32'(e.g));
            chk(e.tag, "reject", 32'(reject_o), 32'(e.rj));
            chk(e.tag, "busy",   32'(busy_o),   32'(e.b));
            chk(e.tag, "data",   32'(data_o),   32'(e.d));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        logic [N*DW-1:0] dv;
        logic [N*DW-1:0] dv2;
        dv  = {8'hC2, 8'hB1, 8'hA0};
        dv2 = {8'h5E, 8'hB1, 8'hA0};
        data_i = dv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "grant",  32'(grant_o),  0);
        chk("R1", "reject", 32'(reject_o), 0);
        chk("R1", "busy",   32'(busy_o),   0);
        chk("R1", "data",   32'(data_o),   0);

        step(3'b001, 0, dv, 3'b001, 3'b000, 1, 8'hA0, "R2 idle grant");
        step(3'b011, 0, dv, 3'b001, 3'b010, 1, 8'hA0, "R7 refuse while held");
        step(3'b010, 1, dv, 3'b000, 3'b010, 0, 8'h00, "R8 release frees");
        step(3'b010, 0, dv, 3'b010, 3'b000, 1, 8'hB1, "R8 pending wins next");
        step(3'b000, 1, dv, 3'b000, 3'b000, 0, 8'h00, "R8 release");
        step(3'b111, 0, dv, 3'b100, 3'b011, 1, 8'hC2, "R3 R5 contest from 2");
        step(3'b000, 1, dv, 3'b000, 3'b000, 0, 8'h00, "R8 release");
        step(3'b111, 0, dv, 3'b001, 3'b110, 1, 8'hA0, "R3 wrap to 0");
        step(3'b000, 1, dv, 3'b000, 3'b000, 0, 8'h00, "R8 release");
        step(3'b000, 0, dv, 3'b000, 3'b000, 0, 8'h00, "R4 idle");
        step(3'b000, 0, dv, 3'b000, 3'b000, 0, 8'h00, "R4 idle");
        step(3'b101, 0, dv, 3'b100, 3'b001, 1, 8'hC2, "R4 start kept at 1");
        step(3'b000, 0, dv, 3'b100, 3'b000, 1, 8'hC2, "R6 owner drops request");
        step(3'b000, 0, dv2, 3'b100, 3'b000, 1, 8'h5E, "R10 pass-through");
        step(3'b000, 1, dv, 3'b000, 3'b000, 0, 8'h00, "R10 free gives zero");
        step(3'b000, 1, dv, 3'b000, 3'b000, 0, 8'h00, "R9 idle release");
        step(3'b010, 1, dv, 3'b010, 3'b000, 1, 8'hB1, "R9 release ignored when free");
        step(3'b000, 1, dv, 3'b000, 3'b000, 0, 8'h00, "R8 release");
        @(negedge clk);
        req_i = '0; release_i = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule